// File: doc/BRIEF.md
# Microprogram Address Breakpoint Unit

This block watches the ROM address bus of a microsequencer. Each microinstruction passes through two ROM output registers before it executes, so the address on the bus runs two cycles ahead of the instruction that is executing. The block compares that prefetch address with an operator-set compare value. The first cycle of a match produces a single-clock trigger pulse. All effects are registered, so they appear at the end of the cycle in which the match is seen.

With breakpoints enabled, the same match also does one of two things, chosen by a mode select. In halt mode it raises a halt request, which stays set until a continue input clears it. In jump mode it issues a one-cycle jump load that carries a full target address. That address is built from two bank bits in the most significant positions and a 14-bit target below them. The operator aims at a microinstruction by setting the compare value to its address plus one or plus two. Plus one stops once the register-bus source fields of that instruction have executed. Plus two stops once all of its fields have executed. The block itself adds no offset.

Top module: `ubrk_unit`

## Requirements
- R1: While reset is active, and on the first clock after it, trig, halt_req and jmp_ld are 0 and jmp_addr is 0.
- R2: trig is 1 for exactly one clock, in the cycle after the first cycle in which rom_addr equals the sampled compare value. A run of consecutive equal cycles gives only that one pulse.
- R3: When brk_en was sampled as 0, a match produces trig only. halt_req and jmp_ld stay 0.
- R4: When brk_en was sampled as 1 and jmp_mode as 0 (halt mode), halt_req becomes 1 in the same cycle as trig. It then stays 1 until a cycle in which cont is 1.
- R5: When brk_en was sampled as 1 and jmp_mode as 1 (jump mode), jmp_ld is 1 for exactly one cycle, together with trig. In that cycle jmp_addr equals {bank_sw, tgt_sw}: the bank bits sit in bits 15:14 and the target in bits 13:0. jmp_addr holds its value between loads.
- R6: cmp_sw, tgt_sw, bank_sw, brk_en and jmp_mode are registered before use. A change applies only to comparisons made from the next clock onward.
- R7: The compare is exact on all 16 bits, with no offset. An address one above or one below the compare value does not trigger.
- R8: If cont is 1 in the same cycle that a new halt match is seen, the halt request is set, not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | input | 16 | ROM prefetch address bus |
| cmp_sw | input | 16 | Compare value switches |
| tgt_sw | input | 14 | Jump target, low 14 address bits |
| bank_sw | input | 2 | Bank bits, the two most significant address bits |
| brk_en | input | 1 | 1 enables halt/jump, 0 allows the trigger only |
| jmp_mode | input | 1 | 0 selects halt, 1 selects jump |
| cont | input | 1 | Clears a pending halt request |
| trig | output | 1 | One-clock trigger pulse on a new match |
| halt_req | output | 1 | Breakpoint halt request, held until cont |
| jmp_ld | output | 1 | One-cycle jump load strobe |
| jmp_addr | output | 16 | Jump target address |

## Verification
A stale sampled switch register would show as a trigger one cycle early or late after the compare value changes. The bench catches this at the next compare of trig. A wrong previous-match flag would show as a repeated trigger during a held match, or as a missed one, within one clock. A halt latch that is set or cleared wrongly would show on halt_req in the cycle after the bad event, and it would persist. The bench compares every output with its model on every clock, so each fault is reported in the cycle where it first appears.

// File: rtl/ubrk_unit.sv
module ubrk_unit #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  localparam int LOW_W = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rom_addr,
  input  logic [ADDR_W-1:0] cmp_sw,
  input  logic [LOW_W-1:0]  tgt_sw,
  input  logic [BANK_W-1:0] bank_sw,
  input  logic              brk_en,
  input  logic              jmp_mode,
  input  logic              cont,
  output logic              trig,
  output logic              halt_req,
  output logic              jmp_ld,
  output logic [ADDR_W-1:0] jmp_addr
);
  logic [ADDR_W-1:0] cmp_q;
  logic [LOW_W-1:0]  tgt_q;
  logic [BANK_W-1:0] bank_q;
  logic              en_q, mode_q, seen_q;
  logic              eq, hit;

  assign eq  = (rom_addr == cmp_q);
  assign hit = eq & ~seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      tgt_q  <= '0;
      bank_q <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_sw;
      tgt_q  <= tgt_sw;
      bank_q <= bank_sw;
      en_q   <= brk_en;
      mode_q <= jmp_mode;
      seen_q <= eq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig     <= 1'b0;
      halt_req <= 1'b0;
      jmp_ld   <= 1'b0;
      jmp_addr <= '0;
    end else begin
      trig   <= hit;
      jmp_ld <= hit & en_q & mode_q;
      if (hit & en_q & ~mode_q) halt_req <= 1'b1;
      else if (cont)            halt_req <= 1'b0;
      if (hit & en_q & mode_q)  jmp_addr <= {bank_q, tgt_q};
    end
  end
endmodule

module ubrk_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic cont,
  input logic trig,
  input logic halt_req,
  input logic jmp_ld,
  input logic [15:0] jmp_addr
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_ld |=> !jmp_ld);
  a_r5_load_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_ld |-> trig);
  a_r4_halt_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> trig);
  a_r4_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !cont) |=> halt_req);
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_ld |=> (jmp_ld || $stable(jmp_addr)));
endmodule

bind ubrk_unit ubrk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cont(cont), .trig(trig),
  .halt_req(halt_req), .jmp_ld(jmp_ld), .jmp_addr(jmp_addr)
);

// File: tb/test_ubrk_unit.sv
module test_ubrk_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] rom_addr = 16'hFFFF;
  logic [15:0] cmp_sw = 16'h0123;
  logic [13:0] tgt_sw = '0;
  logic [1:0]  bank_sw = '0;
  logic brk_en = 1'b0, jmp_mode = 1'b0, cont = 1'b0;
  logic trig, halt_req, jmp_ld;
  logic [15:0] jmp_addr;

  int total = 0, bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  ubrk_unit i_ubrk_unit (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .cmp_sw(cmp_sw),
    .tgt_sw(tgt_sw), .bank_sw(bank_sw), .brk_en(brk_en), .jmp_mode(jmp_mode),
    .cont(cont), .trig(trig), .halt_req(halt_req), .jmp_ld(jmp_ld),
    .jmp_addr(jmp_addr)
  );

  // behavioural reference: switch values as seen at the last edge
  int m_cmp = 0, m_tgt = 0, m_bank = 0;
  bit m_en = 0, m_mode = 0, m_last_eq = 0;
  bit e_trig = 0, e_halt = 0, e_ld = 0;
  int e_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = 0; m_tgt = 0; m_bank = 0; m_en = 0; m_mode = 0; m_last_eq = 0;
      e_trig = 0; e_halt = 0; e_ld = 0; e_addr = 0;
    end else begin
      bit now_eq, fresh;
      now_eq = (int'(rom_addr) == m_cmp);
      fresh = now_eq && !m_last_eq;
      e_trig = fresh;
      e_ld = fresh && m_en && m_mode;
      if (fresh && m_en && !m_mode) e_halt = 1;
      else if (cont) e_halt = 0;
      if (e_ld) e_addr = m_bank * 16384 + m_tgt;
      m_last_eq = now_eq;
      m_cmp = cmp_sw; m_tgt = tgt_sw; m_bank = bank_sw;
      m_en = brk_en; m_mode = jmp_mode;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(phase, "trig", int'(trig), int'(e_trig));
    check(phase, "halt_req", int'(halt_req), int'(e_halt));
    check(phase, "jmp_ld", int'(jmp_ld), int'(e_ld));
    check(phase, "jmp_addr", int'(jmp_addr), e_addr);
  end

  task automatic step(input logic [15:0] a);
    @(negedge clk);
    #0.1 rom_addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset trig", int'(trig), 0);
    check("R1", "reset jmp_addr", int'(jmp_addr), 0);
    rst_n = 1'b1;
    phase = "R2";
    step(16'h0120); step(16'h0121); step(16'h0122);
    step(16'h0123); step(16'h0123); step(16'h0123); step(16'h0124);
    @(negedge clk);
    phase = "R7";
    step(16'h0122); step(16'h0124); step(16'h8123); step(16'h0000);
    phase = "R3";
    step(16'h0123); step(16'h0000); step(16'h0123); step(16'h0000);
    phase = "R4";
    brk_en = 1'b1; jmp_mode = 1'b0;
    step(16'h0000); step(16'h0123);
    repeat (4) step(16'h0000);
    cont = 1'b1; step(16'h0000); cont = 1'b0;
    step(16'h0000);
    phase = "R8";
    cont = 1'b1; step(16'h0123); step(16'h0000);
    cont = 1'b0; step(16'h0000);
    cont = 1'b1; step(16'h0000); cont = 1'b0;
    phase = "R5";
    jmp_mode = 1'b1; bank_sw = 2'b10; tgt_sw = 14'h1ABC;
    step(16'h0000); step(16'h0123); step(16'h0123); step(16'h0000);
    bank_sw = 2'b01; tgt_sw = 14'h0005;
    step(16'h0000); step(16'h0123); step(16'h0000); step(16'h0000);
    phase = "R6";
    brk_en = 1'b0;
    @(negedge clk); #0.1 cmp_sw = 16'h4444; rom_addr = 16'h4444;
    step(16'h4444); step(16'h0000); step(16'h0123); step(16'h4444);
    step(16'h0000); step(16'h0000);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule